// File: doc/BRIEF.md
# Receive DMA Request Watermark Controller

This block watches a frame as it fills a receive byte FIFO and decides when to ask the bus master for a receive DMA transfer. Each cycle it reads the running byte count of the current frame and the end-of-frame strobes from the MAC. It raises one request line when enough of the frame is present. That line stays high until the DMA side acknowledges it. The next frame-start strobe rearms the block.

How many bytes are "enough" depends on a 2-bit watermark code and on three link settings: duplex, a runt-accept enable and a full-duplex padding rule. In half duplex a 64-byte floor keeps runts and collision fragments out of the DMA path. That floor covers the slot time of 512 bit times. Accepting runts, or running in full duplex, removes the floor, so a short frame that completes as valid is still requested. The padding rule puts the floor back in full duplex. The watermark code may only be changed while the receive path is stopped or suspended.

Top module: `rx_dma_wmark_ctrl`

## Requirements
- R1: The watermark code selects the request threshold in bytes: 2'b00 gives 16, 2'b01 gives 64 and 2'b10 gives 112. With no 64-byte floor in force, the request rises the cycle after the byte count first equals the threshold.
- R2: The reserved code 2'b11 behaves exactly like the 64-byte setting, and cfg_code still reads back 2'b11.
- R3: cfg_code is 2'b01 after rst_n and in the cycle after soft_rst. Changing halted alone never alters it.
- R4: A write with cfg_wr_en is taken, and appears on cfg_code the next cycle, only when halted or suspended is high. Otherwise cfg_code is unchanged.
- R5: When full_duplex=0 and runt_accept=0, no request is made while byte_cnt is below 64, whatever the code.
- R6: When full_duplex=1 (with fd_pad_dis=0) or runt_accept=1, a frame that ends with frame_done=1 and frame_ok=1 is requested whatever its length, even below the watermark.
- R7: When full_duplex=1 and fd_pad_dis=1, the 64-byte floor applies even when runt_accept=1.
- R8: dma_req stays high until the cycle after dma_ack and falls there. It is not raised again for the same frame.
- R9: A frame_done with no trigger in force (a runt under the floor, or frame_ok=0) drops the frame, and no request follows until frame_start. frame_start clears the request and rearms the block.
- R10: After reset, no request is raised until the first frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| halted | input | 1 | Receive path stopped; enables configuration writes |
| suspended | input | 1 | Receive path suspended; enables configuration writes |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_code | input | 2 | Watermark code to write |
| cfg_code | output | 2 | Watermark code currently held |
| frame_start | input | 1 | First cycle of a new frame; rearms the block |
| byte_cnt | input | CNT_W | Bytes of the current frame received so far |
| frame_done | input | 1 | Frame end strobe |
| frame_ok | input | 1 | Frame passed its checks, qualified by frame_done |
| full_duplex | input | 1 | Link is full duplex |
| runt_accept | input | 1 | Runt frames are accepted |
| fd_pad_dis | input | 1 | Enforce the 64-byte floor in full duplex |
| dma_ack | input | 1 | DMA side has taken the frame |
| dma_req | output | 1 | Receive DMA request |

## Verification
The bench uses the default parameters: a 14-bit byte count, thresholds of 16, 64 and 112, and a 64-byte floor. Its frames run up to 150 bytes, so all three watermarks and the floor boundary fall inside a single frame. Frames of 30 to 90 bytes end before the larger watermarks, which lets the complete-frame path be seen apart from the threshold path. The behavioural model takes the floor as "padding rule in full duplex, lack of runt-accept in half duplex". This is a different formulation from the one in the RTL, so a slip in the mode logic shows up as a per-cycle mismatch.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

  typedef logic [1:0] wm_code_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REQ   = 2'd2,
    ST_DONE  = 2'd3
  } rx_req_state_t;

  localparam wm_code_t WM_RESET_CODE = 2'b01;

  // Map a watermark code to a byte threshold; reserved code falls back to b1.
  function automatic int unsigned wm_bytes(wm_code_t c, int unsigned b0,
                                           int unsigned b1, int unsigned b2);
    case (c)
      2'b00:   return b0;
      2'b10:   return b2;
      default: return b1;
    endcase
  endfunction

  // Whether the minimum-length floor is in force for the current link mode.
  function automatic logic floor_active(logic fdx, logic runt_ok, logic pad_dis);
    return (!fdx && !runt_ok) || (fdx && pad_dis);
  endfunction

endpackage

// File: rtl/rxwm_cfg_reg.sv
module rxwm_cfg_reg
  import rxwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     halted,
  input  logic     suspended,
  input  logic     wr_en,
  input  wm_code_t wr_code,
  output wm_code_t code_q,
  output logic     wr_taken
);

  logic wr_window;

  assign wr_window = halted || suspended;
  assign wr_taken  = wr_en && wr_window && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= WM_RESET_CODE;
    else if (soft_rst) code_q <= WM_RESET_CODE;
    else if (wr_taken) code_q <= wr_code;
  end

  AST_SOFT_RST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (code_q == 2'b01)); // R3

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !suspended && !soft_rst) |=> $stable(code_q)); // R4

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (halted || suspended) && !soft_rst) |=> (code_q == $past(wr_code))); // R4

endmodule

// File: rtl/rxwm_trigger.sv
module rxwm_trigger
  import rxwm_pkg::*;
#(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned WM_CODE0  = 16,
  parameter int unsigned WM_CODE1  = 64,
  parameter int unsigned WM_CODE2  = 112,
  parameter int unsigned MIN_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wm_code_t         code,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             frame_done,
  input  logic             frame_ok,
  input  logic             full_duplex,
  input  logic             runt_accept,
  input  logic             fd_pad_dis,
  output logic             floor_on,
  output logic             wm_hit,
  output logic             done_hit,
  output logic             trigger
);

  localparam logic [CNT_W-1:0] FLOOR_CNT = CNT_W'(MIN_BYTES);

  logic [CNT_W-1:0] thr;
  logic             past_floor;
  logic             length_ok;

  assign thr        = CNT_W'(wm_bytes(code, WM_CODE0, WM_CODE1, WM_CODE2));
  assign floor_on   = floor_active(full_duplex, runt_accept, fd_pad_dis);
  assign past_floor = (byte_cnt >= FLOOR_CNT);
  assign length_ok  = !floor_on || past_floor;
  assign wm_hit     = (byte_cnt >= thr) && length_ok;
  assign done_hit   = frame_done && frame_ok && length_ok;
  assign trigger    = wm_hit || done_hit;

  AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && !runt_accept && (byte_cnt < FLOOR_CNT)) |-> !trigger); // R5

  AST_PAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && fd_pad_dis && (byte_cnt < FLOOR_CNT)) |-> !trigger); // R7

  AST_SHORT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (((full_duplex && !fd_pad_dis) || (!full_duplex && runt_accept))
      && frame_done && frame_ok) |-> trigger); // R6

endmodule

// File: rtl/rxwm_req_fsm.sv
module rxwm_req_fsm
  import rxwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          frame_start,
  input  logic          trigger,
  input  logic          frame_done,
  input  logic          dma_ack,
  output logic          dma_req,
  output logic          drop_evt,
  output rx_req_state_t state
);

  rx_req_state_t nxt;

  always_comb begin
    nxt = state;
    if (frame_start) begin
      nxt = ST_ARMED;
    end else begin
      case (state)
        ST_ARMED: begin
          if (trigger)         nxt = ST_REQ;
          else if (frame_done) nxt = ST_DONE;
        end
        ST_REQ:   if (dma_ack) nxt = ST_DONE;
        default:  nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= ST_IDLE;
    else if (soft_rst) state <= ST_IDLE;
    else               state <= nxt;
  end

  assign dma_req  = (state == ST_REQ);
  assign drop_evt = (state == ST_ARMED) && !frame_start && !trigger && frame_done;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && !frame_start && !soft_rst) |=> dma_req); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack) |=> !dma_req); // R8

  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DONE) && !frame_start) |=> !dma_req); // R8

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !soft_rst) |=> (!dma_req && (state == ST_DONE))); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !dma_req); // R9

  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !frame_start) |=> (state == ST_IDLE)); // R10

endmodule

// File: rtl/rx_dma_wmark_ctrl.sv
module rx_dma_wmark_ctrl
  import rxwm_pkg::*;
#(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned WM_CODE0  = 16,
  parameter int unsigned WM_CODE1  = 64,
  parameter int unsigned WM_CODE2  = 112,
  parameter int unsigned MIN_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             halted,
  input  logic             suspended,
  input  logic             cfg_wr_en,
  input  logic [1:0]       cfg_wr_code,
  output logic [1:0]       cfg_code,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             frame_done,
  input  logic             frame_ok,
  input  logic             full_duplex,
  input  logic             runt_accept,
  input  logic             fd_pad_dis,
  input  logic             dma_ack,
  output logic             dma_req
);

  wm_code_t      code_q;
  logic          wr_taken;
  logic          floor_on;
  logic          wm_hit;
  logic          done_hit;
  logic          trigger;
  logic          drop_evt;
  rx_req_state_t req_state;

  rxwm_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .halted    (halted),
    .suspended (suspended),
    .wr_en     (cfg_wr_en),
    .wr_code   (cfg_wr_code),
    .code_q    (code_q),
    .wr_taken  (wr_taken)
  );

  rxwm_trigger #(
    .CNT_W     (CNT_W),
    .WM_CODE0  (WM_CODE0),
    .WM_CODE1  (WM_CODE1),
    .WM_CODE2  (WM_CODE2),
    .MIN_BYTES (MIN_BYTES)
  ) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .code        (code_q),
    .byte_cnt    (byte_cnt),
    .frame_done  (frame_done),
    .frame_ok    (frame_ok),
    .full_duplex (full_duplex),
    .runt_accept (runt_accept),
    .fd_pad_dis  (fd_pad_dis),
    .floor_on    (floor_on),
    .wm_hit      (wm_hit),
    .done_hit    (done_hit),
    .trigger     (trigger)
  );

  rxwm_req_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .frame_start (frame_start),
    .trigger     (trigger),
    .frame_done  (frame_done),
    .dma_ack     (dma_ack),
    .dma_req     (dma_req),
    .drop_evt    (drop_evt),
    .state       (req_state)
  );

  assign cfg_code = code_q;

  AST_RESERVED_AS_64: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_q == 2'b11) && !floor_on && !frame_done) |-> (wm_hit == (byte_cnt >= CNT_W'(WM_CODE1)))); // R2

  AST_LOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_q == 2'b00) && !floor_on && (byte_cnt >= CNT_W'(WM_CODE0))) |-> wm_hit); // R1

  AST_CFG_QUIET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_taken && !soft_rst) |=> $stable(cfg_code)); // R4

  AST_DONE_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |-> (frame_done && frame_ok)); // R6

  AST_DROP_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> !(wm_hit || done_hit)); // R9

endmodule

// File: tb/test_rx_dma_wmark_ctrl.sv
module test_rx_dma_wmark_ctrl;

  localparam int CW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic          halted = 1'b0;
  logic          suspended = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [1:0]    cfg_wr_code = 2'b00;
  logic [1:0]    cfg_code;
  logic          frame_start = 1'b0;
  logic [CW-1:0] byte_cnt = '0;
  logic          frame_done = 1'b0;
  logic          frame_ok = 1'b0;
  logic          full_duplex = 1'b0;
  logic          runt_accept = 1'b0;
  logic          fd_pad_dis = 1'b0;
  logic          dma_ack = 1'b0;
  logic          dma_req;

  always #5 clk = ~clk;

  rx_dma_wmark_ctrl i_rx_dma_wmark_ctrl (
    .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst), .halted (halted),
    .suspended (suspended), .cfg_wr_en (cfg_wr_en), .cfg_wr_code (cfg_wr_code),
    .cfg_code (cfg_code), .frame_start (frame_start), .byte_cnt (byte_cnt),
    .frame_done (frame_done), .frame_ok (frame_ok), .full_duplex (full_duplex),
    .runt_accept (runt_accept), .fd_pad_dis (fd_pad_dis), .dma_ack (dma_ack),
    .dma_req (dma_req)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  string tag = "R10";

  // Behavioural model: 0 waiting, 1 collecting, 2 requesting, 3 finished
  int m_phase = 0;
  int m_code  = 1;

  function automatic int limit_for(int c);
    if (c == 0) return 16;
    if (c == 2) return 112;
    return 64;
  endfunction

  task automatic check(string r, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    bit need64, go;
    int cnt;
    @(posedge clk);
    if (!rst_n || soft_rst) begin
      m_phase = 0;
      m_code  = 1;
    end else begin
      cnt    = int'(byte_cnt);
      need64 = full_duplex ? fd_pad_dis : !runt_accept;
      go     = (need64 && cnt < 64) ? 1'b0 :
               ((cnt >= limit_for(m_code)) || (frame_done && frame_ok));
      if (frame_start)                        m_phase = 1;
      else if (m_phase == 1 && go)            m_phase = 2;
      else if (m_phase == 1 && frame_done)    m_phase = 3;
      else if (m_phase == 2 && dma_ack)       m_phase = 3;
      if (cfg_wr_en && (halted || suspended)) m_code = int'(cfg_wr_code);
    end
    @(negedge clk);
    check(tag, int'(dma_req), (m_phase == 2) ? 1 : 0);
    check("R3/R4 code", int'(cfg_code), m_code);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [1:0] c, logic h, logic s);
    cfg_wr_code = c; halted = h; suspended = s; cfg_wr_en = 1'b1;
    step();
    cfg_wr_en = 1'b0; halted = 1'b0; suspended = 1'b0;
  endtask

  task automatic set_mode(logic fdx, logic ra, logic pad);
    full_duplex = fdx; runt_accept = ra; fd_pad_dis = pad;
  endtask

  // Runs one frame; returns the byte count at which dma_req was first seen.
  task automatic frame(int len, bit ok, bit ack_late, output int first);
    first = -1;
    frame_start = 1'b1; byte_cnt = '0;
    step();
    frame_start = 1'b0;
    for (int i = 1; i <= len; i++) begin
      byte_cnt   = CW'(i);
      frame_done = (i == len);
      frame_ok   = ok;
      dma_ack    = !ack_late && (m_phase == 2);
      step();
      if (dma_req && first < 0) first = i;
    end
    frame_done = 1'b0; frame_ok = 1'b0;
    if (ack_late) begin
      dma_ack = 1'b0;
      idle(3);
      check("R8 hold", int'(dma_req), 1);
      dma_ack = 1'b1;
      step();
      dma_ack = 1'b0;
      check("R8 ack clears", int'(dma_req), 0);
    end
    for (int i = 0; i < 3; i++) begin
      dma_ack = (m_phase == 2);
      step();
    end
    dma_ack = 1'b0;
    check("R8 no re-request", int'(dma_req), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int f;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset code", int'(cfg_code), 1);
    check("R10 reset req", int'(dma_req), 0);

    tag = "R10";
    set_mode(1'b1, 1'b0, 1'b0);
    byte_cnt = CW'(200); frame_done = 1'b1; frame_ok = 1'b1;
    idle(3);
    check("R10 no frame_start", int'(dma_req), 0);
    frame_done = 1'b0; frame_ok = 1'b0; byte_cnt = '0;

    tag = "R4";
    wr(2'b10, 1'b0, 1'b0);
    check("R4 blocked write", int'(cfg_code), 1);
    wr(2'b00, 1'b0, 1'b1);
    check("R4 suspended write", int'(cfg_code), 0);
    tag = "R3";
    halted = 1'b1; idle(2); halted = 1'b0; idle(1);
    check("R3 halted keeps code", int'(cfg_code), 0);

    tag = "R1";
    set_mode(1'b1, 1'b0, 1'b0);
    frame(100, 1'b1, 1'b0, f); check("R1 code00", f, 16);
    wr(2'b01, 1'b1, 1'b0);
    frame(100, 1'b1, 1'b0, f); check("R1 code01", f, 64);
    wr(2'b10, 1'b1, 1'b0);
    frame(150, 1'b1, 1'b0, f); check("R1 code10", f, 112);

    tag = "R6";
    frame(90, 1'b1, 1'b0, f); check("R6 full-duplex short of mark", f, 90);
    frame(30, 1'b1, 1'b0, f); check("R6 full-duplex runt", f, 30);
    set_mode(1'b0, 1'b1, 1'b0);
    frame(30, 1'b1, 1'b0, f); check("R6 runt-accept half", f, 30);

    tag = "R9";
    set_mode(1'b1, 1'b0, 1'b0);
    frame(50, 1'b0, 1'b0, f); check("R9 invalid dropped", f, -1);

    tag = "R2";
    wr(2'b11, 1'b1, 1'b0);
    check("R2 readback", int'(cfg_code), 3);
    frame(100, 1'b1, 1'b0, f); check("R2 reserved as 64", f, 64);

    tag = "R5";
    wr(2'b00, 1'b1, 1'b0);
    set_mode(1'b0, 1'b0, 1'b0);
    frame(100, 1'b1, 1'b0, f); check("R5 half floor", f, 64);
    frame(40, 1'b1, 1'b0, f); check("R5 R9 half runt dropped", f, -1);

    tag = "R7";
    set_mode(1'b1, 1'b1, 1'b1);
    frame(30, 1'b1, 1'b0, f); check("R7 pad floor runt", f, -1);
    frame(100, 1'b1, 1'b0, f); check("R7 pad floor long", f, 64);

    tag = "R8";
    set_mode(1'b1, 1'b0, 1'b0);
    frame(40, 1'b1, 1'b1, f); check("R8 late ack first", f, 16);

    tag = "R3";
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    check("R3 soft reset code", int'(cfg_code), 1);
    check("R3 soft reset req", int'(dma_req), 0);
    idle(2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule